// File: doc/BRIEF.md
# Companded Sample Expander with Signalling-Bit Midpoint

This block turns one received 8-bit companded voice code into a signed 14-bit linear sample. A static select picks one of two code conventions: mu-law, or A-law with its alternate-bit inversion. A received code is qualified by a valid strobe. The result is registered and appears one clock later together with its own valid pulse. Between strobes the last sample is held.

Some links take the least significant code bit for in-band signalling. For those links the caller raises a steal flag alongside the code. The block then ignores the received bit 0 and outputs the value halfway between the two codes that bit 0 could have selected. Two identical segment decoders evaluate both candidates every cycle. The top either averages the two candidates or takes the one that matches the received bit.

Control is a two-state machine. `ST_IDLE` means no sample is being presented. `ST_EMIT` means a freshly decoded sample is on the output. The machine moves from `ST_IDLE` to `ST_EMIT` on an input strobe and stays in `ST_EMIT` while strobes keep coming. It returns from `ST_EMIT` to `ST_IDLE` on any cycle without a strobe. Reset forces `ST_IDLE`.

Top module: `cmp_expander`

## Requirements
- R1: While and right after reset (`rst_n` low), `out_valid` is 0 and `out_sample` is 0.
- R2: `out_valid` is 1 in exactly those cycles that follow a cycle with `in_valid` high at the clock edge, and 0 otherwise.
- R3: After a cycle with `in_valid` low, `out_sample` keeps its previous value, whatever `in_code`, `steal_lsb` or `law_sel` do.
- R4: With `law_sel` = 0 (mu-law), all code bits are inverted first. Then bits 6:4 are the segment s, bits 3:0 are the step t, and the magnitude is (2t+33)·2^s − 33. Code 0x80 gives +8031, code 0x00 gives −8031, and codes 0xFF and 0x7F both give 0.
- R5: With `law_sel` = 1 (A-law), the code is XORed with 0x55 first, and s and t are taken as in R4. The magnitude is 2·(2t+1) for s = 0, and 2·(2t+33)·2^(s−1) otherwise. Code 0xAA gives +8064, 0x2A gives −8064, 0xD5 gives +2 and 0x55 gives −2.
- R6: Code bit 7 is the sign: 1 gives a positive sample, 0 gives the two's-complement negative of the magnitude.
- R7: With `steal_lsb` = 1, the received bit 0 has no effect. The output is the exact average of the values R4/R5 give for the code with bit 0 forced to 0 and to 1. For example, mu-law 0xFF gives +1 and A-law 0xD5 gives +4.
- R8: With `steal_lsb` = 0, the output is the R4/R5 value of the full 8-bit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| law_sel | input | 1 | Code convention: 0 mu-law, 1 A-law |
| steal_lsb | input | 1 | 1 when bit 0 of the code carries signalling |
| in_valid | input | 1 | Qualifies `in_code` this cycle |
| in_code | input | 8 | Received companded code |
| out_valid | output | 1 | One-cycle pulse marking a new sample |
| out_sample | output | 14 | Signed linear sample, held between pulses |

## Verification
The expansion is tried with every one of the 256 codes, under both conventions and with the steal flag both off and on. This is 1024 patterns streamed back to back. The full sweep tells the mu-law bias and the A-law linear first segment apart from any other segment handling. It also separates sign handling from the inversion masks, and shows whether bit 0 is really ignored when the flag is set. Targeted codes pin down full scale and the two smallest-magnitude codes of each convention. The averaged smallest codes show the midpoint rounding. An idle stretch with changing inputs shows that the output holds and that the valid pulse tracks the strobe exactly.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    localparam int CODE_W   = 8;
    localparam int SEG_W    = 3;
    localparam int STEP_W   = 4;
    localparam int SAMPLE_W = 14;
    localparam int MU_BIAS  = 33;
    localparam logic [CODE_W-1:0] A_TOGGLE = 8'h55;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } cmp_state_e;
endpackage

// File: rtl/cmp_code_decode.sv
module cmp_code_decode
    import cmp_pkg::*;
#(
    parameter int SW = SAMPLE_W
) (
    input  logic                 law_a,
    input  logic [CODE_W-1:0]    code,
    output logic signed [SW-1:0] value
);
    localparam int MAG_W  = SW - 1;
    localparam int BASE_W = STEP_W + 2;
    localparam logic [MAG_W-1:0] BIAS = MAG_W'(MU_BIAS);

    logic [CODE_W-1:0] mu_code, a_code, eff_code;
    logic [SEG_W-1:0]  seg;
    logic [STEP_W-1:0] stp;
    logic [MAG_W-1:0]  base_ext, shifted, mag_mu, mag_a13, mag_a, mag;

    assign mu_code  = ~code;
    assign a_code   = code ^ A_TOGGLE;
    assign eff_code = law_a ? a_code : mu_code;
    assign seg      = eff_code[STEP_W +: SEG_W];
    assign stp      = eff_code[STEP_W-1:0];

    // (2t+33) built from the step with a leading one and trailing one
    assign base_ext = MAG_W'({1'b1, stp, 1'b1});

    always_comb begin
        shifted = base_ext << seg;
        mag_mu  = shifted - BIAS;
        if (seg == '0)
            mag_a13 = MAG_W'({stp, 1'b1});
        else
            mag_a13 = base_ext << (seg - SEG_W'(1));
        mag_a = {mag_a13[MAG_W-2:0], 1'b0};
        mag   = law_a ? mag_a : mag_mu;
    end

    // bit 7 set means positive
    assign value = code[CODE_W-1] ? $signed({1'b0, mag}) : -$signed({1'b0, mag});

    // R4 / R5: magnitude never exceeds the larger full scale
    always_comb begin
        assert_mag_bound_R5: assert (mag <= MAG_W'(8064))
            else $error("magnitude out of range");
    end
endmodule

// File: rtl/cmp_expander.sv
module cmp_expander
    import cmp_pkg::*;
#(
    parameter int SW = SAMPLE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 law_sel,
    input  logic                 steal_lsb,
    input  logic                 in_valid,
    input  logic [CODE_W-1:0]    in_code,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_sample
);
    localparam int NCAND = 2;

    cmp_state_e state_q, state_d;

    logic signed [SW-1:0] cand_val [NCAND];
    logic signed [SW:0]   pair_sum;
    logic signed [SW-1:0] mid_val, full_val, next_val;

    // two candidates: bit 0 forced low and forced high
    for (genvar g = 0; g < NCAND; g++) begin : g_cand
        cmp_code_decode #(.SW(SW)) u_dec (
            .law_a (law_sel),
            .code  ({in_code[CODE_W-1:1], 1'(g)}),
            .value (cand_val[g])
        );
    end

    assign pair_sum = SW'(0) + {cand_val[0][SW-1], cand_val[0]}
                             + {cand_val[1][SW-1], cand_val[1]};
    assign mid_val  = pair_sum[SW:1];
    assign full_val = in_code[0] ? cand_val[1] : cand_val[0];
    assign next_val = steal_lsb ? mid_val : full_val;

    // R7: adjacent codes always differ by an even amount, so halving is exact
    always_comb begin
        assert_exact_half_R7: assert (pair_sum[0] == 1'b0)
            else $error("midpoint not exact");
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_EMIT;
            ST_EMIT: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_sample <= '0;
        else if (in_valid) out_sample <= next_val;
    end

    assign out_valid = (state_q == ST_EMIT);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_without_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));

    assert_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_sample == '0) || (out_sample[SW-1] == !$past(in_code[CODE_W-1]))));
endmodule

// File: tb/cmp_expander_tb_top.sv
module cmp_expander_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              law_sel = 1'b0;
    logic              steal_lsb = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_code = 8'h00;
    logic              out_valid;
    logic signed [13:0] out_sample;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cmp_expander dut_i (
        .clk(clk), .rst_n(rst_n), .law_sel(law_sel), .steal_lsb(steal_lsb),
        .in_valid(in_valid), .in_code(in_code),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic int ref_val(bit law_a, bit [7:0] c);
        bit [7:0] t;
        int seg, stp, mag;
        t   = law_a ? (c ^ 8'h55) : ~c;
        seg = int'(t[6:4]);
        stp = int'(t[3:0]);
        if (!law_a)        mag = (2*stp + 33) * (1 << seg) - 33;
        else if (seg == 0) mag = 2 * (2*stp + 1);
        else               mag = 2 * (2*stp + 33) * (1 << (seg - 1));
        return c[7] ? mag : -mag;
    endfunction

    function automatic int expect_val(bit law_a, bit st, bit [7:0] c);
        if (st) return (ref_val(law_a, c & 8'hFE) + ref_val(law_a, c | 8'h01)) / 2;
        return ref_val(law_a, c);
    endfunction

    task automatic check(string tag, int got, int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic apply(bit law_a, bit st, bit [7:0] c, int exp, string tag);
        @(negedge clk);
        law_sel = law_a; steal_lsb = st; in_code = c; in_valid = 1'b1;
        @(negedge clk);
        check({tag, " R2 valid"}, int'(out_valid), 1);
        check({tag, " sample"}, int'(out_sample), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 sample in reset", int'(out_sample), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 sample after reset", int'(out_sample), 0);

        // exhaustive sweep: both laws, steal flag off and on, every code
        for (int lw = 0; lw < 2; lw++)
            for (int st = 0; st < 2; st++)
                for (int c = 0; c < 256; c++)
                    apply(bit'(lw), bit'(st), 8'(c), expect_val(bit'(lw), bit'(st), 8'(c)),
                          st ? "R7 steal" : (lw ? "R5/R6/R8 A-law" : "R4/R6/R8 mu-law"));

        // named corner codes
        apply(1'b0, 1'b0, 8'h80,  8031, "R4 mu +full");
        apply(1'b0, 1'b0, 8'h00, -8031, "R4 mu -full");
        apply(1'b0, 1'b0, 8'hFF,     0, "R4 mu +zero");
        apply(1'b0, 1'b0, 8'h7F,     0, "R4 mu -zero");
        apply(1'b1, 1'b0, 8'hAA,  8064, "R5 A +full");
        apply(1'b1, 1'b0, 8'h2A, -8064, "R5 A -full");
        apply(1'b1, 1'b0, 8'hD5,     2, "R5 A +small");
        apply(1'b1, 1'b0, 8'h55,    -2, "R5 A -small");
        apply(1'b0, 1'b1, 8'hFF,     1, "R7 mu midpoint");
        apply(1'b1, 1'b1, 8'hD5,     4, "R7 A midpoint");
        apply(1'b1, 1'b1, 8'hD4,     4, "R7 bit0 ignored");
        apply(1'b0, 1'b1, 8'h7E,    -1, "R7/R6 mu negative midpoint");

        // idle stretch with busy inputs
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            in_code = 8'(k * 37 + 5); law_sel = ~law_sel; steal_lsb = ~steal_lsb;
            @(negedge clk);
            check("R2 no pulse when idle", int'(out_valid), 0);
            check("R3 sample held", int'(out_sample), -1);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule